// File: doc/BRIEF.md
# USB Frame Number Tracker

This block keeps the current 11-bit USB frame number and, in high-speed operation, the index of the last 125 µs microframe. Both are presented as byte-wide read values: a low frame byte, a high frame byte carrying the three top frame bits, and a microframe byte. The block takes a start-of-frame strobe from an upstream token decoder, together with the 11-bit frame field and a flag that marks a CRC failure on that token. A free-running microsecond tick lets it measure how long it has been since the last start-of-frame.

If no start-of-frame arrives within the expected window, or one arrives with a bad CRC, the block generates an internal start-of-frame and advances its own count. Every accepted or generated start-of-frame also produces a single-clock event pulse. The tracker has two states. `TRK_WAIT_FIRST` is entered at reset. In this state there is no reference yet, so timeouts and corrupted tokens are ignored. The block moves from `TRK_WAIT_FIRST` to `TRK_LOCKED` on the first start-of-frame with a good CRC. `TRK_LOCKED` stays active until reset. While locked, a good token loads the count. A bad token or an expired window advances the count.

Top module: `usb_frame_tracker`

## Requirements
- R1: After reset the frame number is 0, the microframe index is 0, the event pulse is low, and the tracker is in `TRK_WAIT_FIRST`.
- R2: A start-of-frame strobe with a good CRC loads the 11-bit frame field into the frame number, visible on the clock after the strobe is sampled.
- R3: `frame_lo` holds frame bits 7..0. `frame_hi` bits 2..0 hold frame bits 10..8, and `frame_hi` bits 7..3 read 0. `uframe` bits 2..0 hold the microframe index, and `uframe` bits 7..3 read 0.
- R4: In `TRK_WAIT_FIRST`, no internal start-of-frame is ever generated, and a strobe with a bad CRC changes nothing and gives no pulse.
- R5: In `TRK_LOCKED` at full speed, if `FS_LIMIT` microsecond ticks pass with no start-of-frame, an internal start-of-frame increments the frame number. The window restarts after every real or internal start-of-frame.
- R6: In `TRK_LOCKED`, a strobe with a bad CRC is treated as an internal start-of-frame at once: its frame field is ignored and the stored frame number advances.
- R7: An internal increment of frame number 2047 gives 0.
- R8: In high-speed mode, a good start-of-frame whose frame field differs from the stored number sets the microframe index to 0. One with an equal frame field advances the index by 1, modulo 8.
- R9: In high-speed mode, an internal start-of-frame advances the microframe index. The frame number is incremented only when the index wraps from 7 to 0. The timeout window is then `HS_LIMIT` ticks.
- R10: When high-speed mode is off, the microframe index is 0 from the next clock on.
- R11: Each real or internal start-of-frame raises `sof_pulse` for exactly one clock, on the same clock as the register update.
- R12: A good start-of-frame that arrives in the same cycle as a window expiry takes precedence: the count is loaded from the token, with no extra increment and a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_strobe | input | 1 | Start-of-frame token received (one clock) |
| sof_frame | input | 11 | Frame field of the received token |
| sof_crc_err | input | 1 | CRC of the token was bad (qualifies `sof_strobe`) |
| hs_mode | input | 1 | High-speed operation |
| us_tick | input | 1 | One-clock pulse every microsecond |
| frame_hi | output | 8 | Frame number bits 10..8 in bits 2..0, upper bits 0 |
| frame_lo | output | 8 | Frame number bits 7..0 |
| uframe | output | 8 | Microframe index in bits 2..0, upper bits 0 |
| sof_pulse | output | 1 | One-clock pulse per real or internal start-of-frame |

## Verification
Directed scenarios cover the following cases:
- Good tokens with different frame values, which separate a faithful copy from a byte-swapped or truncated copy.
- Full-speed silence measured in clock cycles up to the generated event, which shows an off-by-one in the window and whether the window restarts.
- Bad-CRC tokens before and after lock, which show whether the waiting state really ignores them.
- A token placed exactly on the expiry cycle, which shows the precedence rule.
- High-speed runs of repeated and changing frame fields, plus chains of bad tokens across index 7, which show the reset-versus-advance rule and the carry into the frame number.
- Frame value 2047, which shows the wrap.

// File: rtl/usb_frame_pkg.sv
package usb_frame_pkg;
    localparam int FRAME_W  = 11;
    localparam int UFRAME_W = 3;

    typedef enum logic [0:0] {
        TRK_WAIT_FIRST = 1'b0,
        TRK_LOCKED     = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_REAL  = 2'd1,
        EV_SYNTH = 2'd2
    } sof_ev_t;
endpackage

// File: rtl/sof_watchdog.sv
module sof_watchdog #(
    parameter int FS_LIMIT = 1020,
    parameter int HS_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic hs_mode,
    input  logic us_tick,
    output logic expire
);
    localparam int MAX_LIMIT = (FS_LIMIT > HS_LIMIT) ? FS_LIMIT : HS_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_tick;

    always_comb begin
        last_tick = hs_mode ? CNT_W'(HS_LIMIT - 1) : CNT_W'(FS_LIMIT - 1);
        expire    = enable && us_tick && (cnt >= last_tick);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || restart || expire) begin
            cnt <= '0;
        end else if (us_tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frame_regs.sv
module frame_regs
    import usb_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  sof_ev_t             ev,
    input  logic [FRAME_W-1:0]  rx_frame,
    input  logic                hs_mode,
    output logic [FRAME_W-1:0]  frame,
    output logic [UFRAME_W-1:0] uframe,
    output logic                pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame  <= '0;
            uframe <= '0;
            pulse  <= 1'b0;
        end else begin
            pulse <= (ev != EV_NONE);
            unique case (ev)
                EV_REAL: begin
                    frame <= rx_frame;
                    if (hs_mode && (rx_frame == frame))
                        uframe <= uframe + UFRAME_W'(1);
                    else
                        uframe <= '0;
                end
                EV_SYNTH: begin
                    if (hs_mode) begin
                        uframe <= uframe + UFRAME_W'(1);
                        if (uframe == '1)
                            frame <= frame + FRAME_W'(1);
                    end else begin
                        uframe <= '0;
                        frame  <= frame + FRAME_W'(1);
                    end
                end
                EV_NONE: begin
                    if (!hs_mode)
                        uframe <= '0;
                end
                default: begin
                    uframe <= uframe;
                end
            endcase
        end
    end
endmodule

// File: rtl/usb_frame_tracker.sv
module usb_frame_tracker
    import usb_frame_pkg::*;
#(
    parameter int FS_LIMIT = 1020,
    parameter int HS_LIMIT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof_strobe,
    input  logic [10:0] sof_frame,
    input  logic        sof_crc_err,
    input  logic        hs_mode,
    input  logic        us_tick,
    output logic [7:0]  frame_hi,
    output logic [7:0]  frame_lo,
    output logic [7:0]  uframe,
    output logic        sof_pulse
);
    trk_state_t          state, state_nxt;
    sof_ev_t             ev;
    logic                tmr_en;
    logic                expire;
    logic                good_tok, bad_tok;
    logic [FRAME_W-1:0]  frame_q;
    logic [UFRAME_W-1:0] uframe_q;

    assign good_tok = sof_strobe && !sof_crc_err;
    assign bad_tok  = sof_strobe && sof_crc_err;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TRK_WAIT_FIRST;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        ev        = EV_NONE;
        tmr_en    = 1'b0;
        unique case (state)
            TRK_WAIT_FIRST: begin
                if (good_tok) begin
                    ev        = EV_REAL;
                    state_nxt = TRK_LOCKED;
                end
            end
            TRK_LOCKED: begin
                tmr_en = 1'b1;
                if (good_tok)
                    ev = EV_REAL;
                else if (bad_tok || expire)
                    ev = EV_SYNTH;
            end
        endcase
    end

    sof_watchdog #(
        .FS_LIMIT (FS_LIMIT),
        .HS_LIMIT (HS_LIMIT)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tmr_en),
        .restart (ev != EV_NONE),
        .hs_mode (hs_mode),
        .us_tick (us_tick),
        .expire  (expire)
    );

    frame_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .rx_frame (sof_frame),
        .hs_mode  (hs_mode),
        .frame    (frame_q),
        .uframe   (uframe_q),
        .pulse    (sof_pulse)
    );

    assign frame_lo = frame_q[7:0];
    assign frame_hi = {5'b0, frame_q[FRAME_W-1:8]};
    assign uframe   = {5'b0, uframe_q};
endmodule

// File: rtl/tracker_chk.sv
module tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sof_strobe,
    input logic [10:0] sof_frame,
    input logic        sof_crc_err,
    input logic        hs_mode,
    input logic [7:0]  frame_hi,
    input logic [7:0]  frame_lo,
    input logic [7:0]  uframe,
    input logic        sof_pulse
);
    logic [10:0] fr;
    assign fr = {frame_hi[2:0], frame_lo};

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hi[7:3] == 5'd0) && (uframe[7:3] == 5'd0)); // R3

    AST_REAL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_strobe && !sof_crc_err) |=> (fr == $past(sof_frame)) && sof_pulse); // R2

    AST_FS_UFRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_mode |=> (uframe[2:0] == 3'd0)); // R10

    AST_FS_SYNTH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_pulse && !$past(sof_strobe && !sof_crc_err) && !$past(hs_mode))
        |-> (fr == $past(fr) + 11'd1)); // R5

    AST_HS_SAME_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && sof_strobe && !sof_crc_err && (fr == sof_frame))
        |=> (uframe[2:0] == $past(uframe[2:0]) + 3'd1)); // R8
endmodule

bind usb_frame_tracker tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_strobe  (sof_strobe),
    .sof_frame   (sof_frame),
    .sof_crc_err (sof_crc_err),
    .hs_mode     (hs_mode),
    .frame_hi    (frame_hi),
    .frame_lo    (frame_lo),
    .uframe      (uframe),
    .sof_pulse   (sof_pulse)
);

// File: tb/sim_usb_frame_tracker.sv
module sim_usb_frame_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int FS_LIM = 1020;
    localparam int HS_LIM = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_strobe = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        sof_crc_err = 1'b0;
    logic        hs_mode = 1'b0;
    logic        us_tick = 1'b1;
    logic [7:0]  frame_hi, frame_lo, uframe;
    logic        sof_pulse;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_frame_tracker #(.FS_LIMIT(FS_LIM), .HS_LIMIT(HS_LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .sof_strobe(sof_strobe), .sof_frame(sof_frame),
        .sof_crc_err(sof_crc_err), .hs_mode(hs_mode), .us_tick(us_tick),
        .frame_hi(frame_hi), .frame_lo(frame_lo), .uframe(uframe), .sof_pulse(sof_pulse)
    );

    function automatic int cur_frame();
        return int'({frame_hi[2:0], frame_lo});
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where the update is visible
    task automatic send_sof(input int f, input logic bad);
        sof_strobe  = 1'b1;
        sof_frame   = 11'(f);
        sof_crc_err = bad;
        @(negedge clk);
        sof_strobe  = 1'b0;
        sof_crc_err = 1'b0;
    endtask

    task automatic wait_pulse(output int n, input int maxn);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sof_pulse && n < maxn);
    endtask

    task automatic t_reset();
        int seen = 0;
        chk("R1 frame", cur_frame(), 0);
        chk("R1 uframe", int'(uframe), 0);
        chk("R1 pulse", int'(sof_pulse), 0);
        for (int i = 0; i < FS_LIM + 80; i++) begin
            @(negedge clk);
            if (sof_pulse) seen++;
        end
        chk("R4 no timeout while waiting", seen, 0);
        send_sof(11'h3C5, 1'b1);
        chk("R4 bad token pulse", int'(sof_pulse), 0);
        chk("R4 bad token frame", cur_frame(), 0);
    endtask

    task automatic t_real_copy();
        send_sof(11'h5A3, 1'b0);
        chk("R2 frame copy", cur_frame(), 11'h5A3);
        chk("R3 frame_hi", int'(frame_hi), 8'h05);
        chk("R3 frame_lo", int'(frame_lo), 8'hA3);
        chk("R11 pulse on real", int'(sof_pulse), 1);
        chk("R10 uframe fs", int'(uframe), 0);
        @(negedge clk);
        chk("R11 pulse one clock", int'(sof_pulse), 0);
    endtask

    task automatic t_fs_timeout();
        int n;
        send_sof(11'h2F0, 1'b0);
        wait_pulse(n, FS_LIM + 20);
        chk("R5 window length", n, FS_LIM);
        chk("R5 frame incremented", cur_frame(), 11'h2F1);
        wait_pulse(n, FS_LIM + 20);
        chk("R5 window restarts", n, FS_LIM);
        chk("R5 second increment", cur_frame(), 11'h2F2);
    endtask

    task automatic t_crc_locked();
        send_sof(11'h123, 1'b1);
        chk("R6 bad token advances", cur_frame(), 11'h2F3);
        chk("R6 bad token pulse", int'(sof_pulse), 1);
    endtask

    task automatic t_wrap();
        send_sof(11'd2047, 1'b0);
        chk("R2 load 2047", cur_frame(), 2047);
        send_sof(11'd5, 1'b1);
        chk("R7 wrap to 0", cur_frame(), 0);
    endtask

    task automatic t_race();
        int seen = 0;
        send_sof(11'h100, 1'b0);
        for (int i = 0; i < FS_LIM - 1; i++) @(negedge clk);
        send_sof(11'h200, 1'b0);
        chk("R12 token wins", cur_frame(), 11'h200);
        chk("R12 pulse", int'(sof_pulse), 1);
        @(negedge clk);
        if (sof_pulse) seen++;
        chk("R12 single pulse", seen, 0);
        chk("R12 no extra step", cur_frame(), 11'h200);
    endtask

    task automatic t_hs();
        int n;
        hs_mode = 1'b1;
        send_sof(11'h010, 1'b0);
        chk("R8 new frame uframe", int'(uframe), 0);
        send_sof(11'h010, 1'b0);
        chk("R8 same frame +1", int'(uframe), 1);
        send_sof(11'h010, 1'b0);
        chk("R8 same frame +2", int'(uframe), 2);
        send_sof(11'h011, 1'b0);
        chk("R8 new frame resets", int'(uframe), 0);
        wait_pulse(n, HS_LIM + 20);
        chk("R9 hs window", n, HS_LIM);
        chk("R9 uframe advanced", int'(uframe), 1);
        chk("R9 frame held", cur_frame(), 11'h011);
        for (int i = 0; i < 6; i++) send_sof(11'h7FF, 1'b1);
        chk("R9 uframe at 7", int'(uframe), 7);
        chk("R9 frame still held", cur_frame(), 11'h011);
        send_sof(11'h7FF, 1'b1);
        chk("R9 uframe wrap", int'(uframe), 0);
        chk("R9 frame carry", cur_frame(), 11'h012);
        send_sof(11'h7FF, 1'b1);
        chk("R9 uframe 1 again", int'(uframe), 1);
        hs_mode = 1'b0;
        @(negedge clk);
        chk("R10 fs clears uframe", int'(uframe), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_real_copy();
        t_fs_timeout();
        t_crc_locked();
        t_wrap();
        t_race();
        t_hs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule